// File: doc/BRIEF.md
# Arithmetic and Logic Unit with Sign, Zero, Carry and Overflow Flags

This block is a purely combinational datapath unit of parameterizable width. It takes two operands and a two-bit operation code and returns one of four results: the sum, the difference, the bitwise AND or the bitwise OR of the operands. Alongside the result it gives four condition bits that downstream logic can store or test: the sign of the result, whether the result is zero, the carry out of the adder, and signed overflow.

Addition and subtraction share one adder. The low bit of the operation code selects the mode. When it is set, the second operand is inverted and the adder's carry input is forced to one, so the adder forms the two's-complement difference. A parameter selects how the adder is built: a bit-serial carry chain, or a logarithmic-depth parallel-prefix network. Both forms give identical results at the ports.

The carry and overflow bits are meaningful only for the two arithmetic codes. For the bitwise codes both are held at zero. The sign and zero bits always describe the selected result, whatever the code.

Top module: `alu_nzcv`

## Requirements
- R1: Operation code 2'b00 gives result = A + B modulo 2^WIDTH.
- R2: Operation code 2'b01 gives result = A - B modulo 2^WIDTH.
- R3: Operation code 2'b10 gives result = A AND B, bit by bit.
- R4: Operation code 2'b11 gives result = A OR B, bit by bit.
- R5: flag_n equals bit WIDTH-1 of the result for every operation code.
- R6: flag_z is 1 exactly when every bit of the result is 0, for every operation code.
- R7: On code 2'b00, flag_c is the carry out of the unsigned WIDTH-bit addition.
- R8: On code 2'b01, flag_c is 1 exactly when A >= B as unsigned numbers (carry means no borrow).
- R9: On code 2'b00, flag_v is 1 exactly when A and B have the same sign bit and the result's sign bit differs from it.
- R10: On code 2'b01, flag_v is 1 exactly when A and B have different sign bits and the result's sign bit differs from A's.
- R11: On codes 2'b10 and 2'b11, flag_c and flag_v are both 0, even for operands whose sum would carry or overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| op_sel | input | 2 | Operation code: 00 add, 01 subtract, 10 AND, 11 OR |
| result | output | WIDTH | Selected result |
| flag_n | output | 1 | Sign of result |
| flag_z | output | 1 | Result is all zeros |
| flag_c | output | 1 | Adder carry out; 0 for bitwise codes |
| flag_v | output | 1 | Signed overflow; 0 for bitwise codes |

## Verification
The block holds no state. A fault in the operand inversion, the carry input or a prefix cell therefore shows on the same evaluation as a wrong result or flag, and there is no delay before it appears. Carry-chain faults tend to hide until an operand pattern actually propagates a carry across the broken column. For that reason the directed cases include all-ones plus one, extreme signed values and equal operands, and a deterministic sweep then exercises many carry lengths. A gating fault on the carry or overflow bit shows only under a bitwise code with operands that would overflow if they were added. The logic cases use exactly such operands.

// File: rtl/alu_nzcv_pkg.sv
package alu_nzcv_pkg;

   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_SUB = 2'b01,
      OP_AND = 2'b10,
      OP_OR  = 2'b11
   } alu_op_e;

   typedef struct packed {
      logic neg;
      logic zero;
      logic carry;
      logic ovf;
   } alu_flags_t;

   localparam int ADDER_RIPPLE = 0;
   localparam int ADDER_PREFIX = 1;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int WIDTH       = 32,
   parameter int ADDER_STYLE = 1
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             subtract,
   output logic [WIDTH-1:0] sum,
   output logic             carry_out
);
   import alu_nzcv_pkg::*;

   localparam int STAGES = (WIDTH > 1) ? $clog2(WIDTH) : 1;

   logic [WIDTH-1:0] b_eff;
   logic             cin;
   logic [WIDTH-1:0] gen0;
   logic [WIDTH-1:0] prop0;
   logic [WIDTH-1:0] carry_into;

   assign b_eff = op_b ^ {WIDTH{subtract}};
   assign cin   = subtract;
   assign gen0  = op_a & b_eff;
   assign prop0 = op_a ^ b_eff;

   generate
      if (ADDER_STYLE == ADDER_RIPPLE) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_col
            assign chain[i+1] = gen0[i] | (prop0[i] & chain[i]);
         end
         assign carry_into = chain[WIDTH-1:0];
         assign carry_out  = chain[WIDTH];
      end else if (ADDER_STYLE == ADDER_PREFIX) begin : g_prefix
         logic [WIDTH-1:0] grp_g [0:STAGES];
         logic [WIDTH-1:0] grp_p [0:STAGES];
         assign grp_g[0] = gen0;
         assign grp_p[0] = prop0;
         for (genvar s = 1; s <= STAGES; s++) begin : g_lvl
            localparam int DIST = 1 << (s - 1);
            for (genvar i = 0; i < WIDTH; i++) begin : g_cell
               if (i >= DIST) begin : g_black
                  assign grp_g[s][i] = grp_g[s-1][i] | (grp_p[s-1][i] & grp_g[s-1][i-DIST]);
                  assign grp_p[s][i] = grp_p[s-1][i] & grp_p[s-1][i-DIST];
               end else begin : g_pass
                  assign grp_g[s][i] = grp_g[s-1][i];
                  assign grp_p[s][i] = grp_p[s-1][i];
               end
            end
         end
         assign carry_into[0] = cin;
         for (genvar i = 1; i < WIDTH; i++) begin : g_cin
            assign carry_into[i] = grp_g[STAGES][i-1] | (grp_p[STAGES][i-1] & cin);
         end
         assign carry_out = grp_g[STAGES][WIDTH-1] | (grp_p[STAGES][WIDTH-1] & cin);
      end else begin : g_bad_style
         $error("alu_addsub: ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   assign sum = prop0 ^ carry_into;

   // R1/R2: the structural adder must agree with plain modular arithmetic.
   always_comb begin
      a_r1_adder_matches : assert ({carry_out, sum} ==
         ({1'b0, op_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin}))
         else $error("adder network disagrees with arithmetic sum");
   end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             pick_or,
   output logic [WIDTH-1:0] out
);
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign out[i] = pick_or ? (op_a[i] | op_b[i]) : (op_a[i] & op_b[i]);
      end
   endgenerate
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen #(
   parameter int WIDTH = 32
) (
   input  logic [1:0]       op,
   input  logic [WIDTH-1:0] res,
   input  logic             a_sign,
   input  logic             b_sign,
   input  logic             sum_sign,
   input  logic             adder_cout,
   output alu_nzcv_pkg::alu_flags_t flags
);
   logic is_arith;
   logic signs_agree;

   assign is_arith    = ~op[1];
   // Effective operand signs agree: same for add, opposite for subtract.
   assign signs_agree = ~(a_sign ^ b_sign ^ op[0]);

   assign flags.neg   = res[WIDTH-1];
   assign flags.zero  = ~|res;
   assign flags.carry = is_arith & adder_cout;
   assign flags.ovf   = is_arith & signs_agree & (a_sign ^ sum_sign);
endmodule

// File: rtl/alu_nzcv.sv
module alu_nzcv #(
   parameter int WIDTH       = 32,
   parameter int ADDER_STYLE = 1
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic [1:0]       op_sel,
   output logic [WIDTH-1:0] result,
   output logic             flag_n,
   output logic             flag_z,
   output logic             flag_c,
   output logic             flag_v
);
   import alu_nzcv_pkg::*;

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_width_check
         $error("alu_nzcv: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] sum;
   logic             cout;
   logic [WIDTH-1:0] logic_out;
   alu_flags_t       flags;

   alu_addsub #(.WIDTH(WIDTH), .ADDER_STYLE(ADDER_STYLE)) u_addsub (
      .op_a      (a_in),
      .op_b      (b_in),
      .subtract  (op_sel[0]),
      .sum       (sum),
      .carry_out (cout)
   );

   alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
      .op_a    (a_in),
      .op_b    (b_in),
      .pick_or (op_sel[0]),
      .out     (logic_out)
   );

   assign result = op_sel[1] ? logic_out : sum;

   alu_flag_gen #(.WIDTH(WIDTH)) u_flags (
      .op         (op_sel),
      .res        (result),
      .a_sign     (a_in[MSB]),
      .b_sign     (b_in[MSB]),
      .sum_sign   (sum[MSB]),
      .adder_cout (cout),
      .flags      (flags)
   );

   assign flag_n = flags.neg;
   assign flag_z = flags.zero;
   assign flag_c = flags.carry;
   assign flag_v = flags.ovf;

   always_comb begin
      // R11: bitwise codes never report carry or overflow
      if (op_sel[1]) begin
         a_r11_logic_no_cv : assert (!flag_c && !flag_v)
            else $error("carry/overflow set on bitwise code");
      end
      // R8: subtract carry is the unsigned no-borrow test
      if (op_sel == OP_SUB) begin
         a_r8_sub_carry : assert (flag_c == (a_in >= b_in))
            else $error("subtract carry disagrees with unsigned compare");
      end
      // R9/R10: overflow implies result sign differs from A
      if (flag_v) begin
         a_r9_ovf_sign : assert (result[MSB] != a_in[MSB])
            else $error("overflow with unchanged sign");
      end
      // R5: AND result sign follows both operand signs
      if (op_sel == OP_AND) begin
         a_r5_and_sign : assert (flag_n == (a_in[MSB] & b_in[MSB]))
            else $error("sign flag wrong for AND");
      end
      // R6: OR result is zero only for two zero operands
      if (op_sel == OP_OR) begin
         a_r6_or_zero : assert (flag_z == ((a_in == '0) && (b_in == '0)))
            else $error("zero flag wrong for OR");
      end
   end

endmodule

// File: tb/alu_nzcv_bench.sv
`timescale 1ns/1ps
module alu_nzcv_bench;
   localparam int W = 32;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic [1:0]   op = 2'b00;
   logic [W-1:0] res;
   logic fn, fz, fc, fv;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   alu_nzcv u_alu_nzcv (
      .a_in(a), .b_in(b), .op_sel(op),
      .result(res), .flag_n(fn), .flag_z(fz), .flag_c(fc), .flag_v(fv)
   );

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tag, op, a, b, act, exp);
      end
   endtask

   // Independent reference model built from the requirements.
   task automatic apply(input logic [1:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
      logic [W:0] wide;
      logic [W-1:0] er;
      logic ec, ev;
      longint sx, sy, sr;
      sx = longint'($signed(x));
      sy = longint'($signed(y));
      ec = 0; ev = 0; er = '0;
      case (o)
         2'b00: begin
            wide = {1'b0, x} + {1'b0, y};
            er = wide[W-1:0]; ec = wide[W];
            sr = sx + sy;
            ev = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
         end
         2'b01: begin
            er = x - y; ec = (x >= y);
            sr = sx - sy;
            ev = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
         end
         2'b10: er = x & y;
         default: er = x | y;
      endcase
      @(negedge clk);
      op = o; a = x; b = y;
      #1;
      case (o)
         2'b00: begin chk("R1 result", res, er); chk("R7 carry", W'(fc), W'(ec)); chk("R9 ovf", W'(fv), W'(ev)); end
         2'b01: begin chk("R2 result", res, er); chk("R8 carry", W'(fc), W'(ec)); chk("R10 ovf", W'(fv), W'(ev)); end
         2'b10: begin chk("R3 result", res, er); chk("R11 carry", W'(fc), '0); chk("R11 ovf", W'(fv), '0); end
         default: begin chk("R4 result", res, er); chk("R11 carry", W'(fc), '0); chk("R11 ovf", W'(fv), '0); end
      endcase
      chk("R5 neg", W'(fn), W'(er[W-1]));
      chk("R6 zero", W'(fz), W'(er == '0));
   endtask

   task automatic t_idle();
      #1;
      chk("R6 idle zero", W'(fz), W'(1));
      chk("R1 idle result", res, '0);
      chk("R7 idle carry", W'(fc), '0);
   endtask

   task automatic t_add();
      apply(2'b00, 32'd5, 32'd7);
      apply(2'b00, 32'hFFFF_FFFF, 32'd1);            // carry, zero result
      apply(2'b00, 32'h7FFF_FFFF, 32'd1);            // positive overflow
      apply(2'b00, 32'h8000_0000, 32'h8000_0000);    // carry and negative overflow
      apply(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);    // -1 + -1
      apply(2'b00, 32'h8000_0000, 32'h7FFF_FFFF);
   endtask

   task automatic t_sub();
      apply(2'b01, 32'd5, 32'd3);
      apply(2'b01, 32'd3, 32'd5);                    // borrow
      apply(2'b01, 32'h1234_5678, 32'h1234_5678);    // equal: carry set, zero
      apply(2'b01, 32'h8000_0000, 32'd1);            // min - 1 overflows
      apply(2'b01, 32'h7FFF_FFFF, 32'hFFFF_FFFF);    // max - (-1) overflows
      apply(2'b01, 32'd0, 32'h8000_0000);            // 0 - min overflows
      apply(2'b01, 32'd0, 32'd0);
   endtask

   task automatic t_logic();
      apply(2'b10, 32'hF0F0_F0F0, 32'hFF00_FF00);
      apply(2'b10, 32'h8000_0000, 32'h8000_0000);    // would carry/overflow if added
      apply(2'b10, 32'hAAAA_AAAA, 32'h5555_5555);    // zero result
      apply(2'b11, 32'hF0F0_0000, 32'h0000_0F0F);
      apply(2'b11, 32'h7FFF_FFFF, 32'h0000_0001);    // would overflow if added
      apply(2'b11, 32'd0, 32'd0);
   endtask

   task automatic t_sweep();
      logic [W-1:0] s;
      s = 32'hACE1_2468;
      for (int i = 0; i < 400; i++) begin
         logic [W-1:0] x;
         s = {s[W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
         x = s;
         s = {s[W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
         if (i % 7 == 0) x = ~s;                     // long carry chains
         apply(2'(i), x, {s[15:0], s[31:16]});
      end
   endtask

   initial begin
      t_idle();
      t_add();
      t_sub();
      t_logic();
      t_sweep();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule